// File: doc/BRIEF.md
# Indirect Register Access Window

This block puts a large register space behind a 32-byte I/O aperture that holds only two 32-bit ports. The host first writes a target address into an address latch through one port. It then reads or writes the data port, and that access goes to the internal register file at the latched address. Any other offset in the aperture reads as zero and ignores writes.

Before a data-port access is forwarded, the latched address is sorted into one of four regions. Only the register region is forwarded. The undefined, flash and unknown regions are refused without any effect: a read returns zero and a write is discarded. The region of the most recent refusal is kept in a sticky cause output, which a new write to the address latch clears.

The host side uses a valid/ready request handshake. Every accepted request, read or write, returns a response pulse exactly one cycle later. The internal register file holds 64 dwords, selected by bits [7:2] of the latched address.

Top module: `indirect_window`

## Requirements
- R1: After a synchronous active-high reset, the address latch and all 64 internal registers are 0, `reject_cause` is 0, `rsp_valid` is low and `host_ready` is high.
- R2: A write to aperture offset 0x00 stores all 32 bits of write data in the address latch. A read of offset 0x00 returns the latched value unchanged.
- R3: The aperture offset is `host_addr[4:0]`. An access to any offset other than 0x00 or 0x04 returns zero on a read and changes neither the latch nor any register on a write.
- R4: With the latch below 0x1FFFF, a data-port access at offset 0x04 reaches internal register `latch[7:2]`. A write stores the data there, a read returns the stored value, and `reject_cause` does not change.
- R5: With the latch in 0x1FFFF..0x7FFFE (undefined region), a data-port read returns zero, a write changes no register, and `reject_cause` becomes 2'b01.
- R6: With the latch in 0x7FFFF..0xFFFFE (flash region), data-port accesses are refused in the same way, and `reject_cause` becomes 2'b10.
- R7: With the latch at 0xFFFFF or above (unknown region), data-port accesses are refused in the same way, and `reject_cause` becomes 2'b11.
- R8: `reject_cause` keeps the region of the latest refused access until the address latch is written, and that write clears it to 2'b00.
- R9: Each request accepted (`host_valid` and `host_ready` both high at a clock edge) gives exactly one `rsp_valid` pulse in the next cycle. Write responses carry zero data. No request means no response.
- R10: Back-to-back requests are accepted on consecutive cycles. A data access in the cycle right after an address write uses the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Block can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset within the aperture |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes and refused reads |
| reject_cause | output | 2 | Sticky refusal region: 00 none, 01 undefined, 10 flash, 11 unknown |

## Verification
The bench aims at the region edges. It uses 0x1FFFE and 0x1FFFF, 0x7FFFE and 0x7FFFF, 0xFFFFE and 0xFFFFF, and the all-ones address. An off-by-one comparison would forward a refused address, or refuse a legal one, and the cause code would then be wrong. After writes to unused offsets and refused writes, the bench reads back the latch and the register file. A decoder that leaked these writes would show changed values there. Address writes followed at once by data accesses expose a stale latch. Sequences of refusals in different regions, mixed with forwarded accesses, expose a cause flag that clears, or fails to update, at the wrong time.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 5;

  localparam logic [OFF_W-1:0] OFF_ADDR = 5'h00;
  localparam logic [OFF_W-1:0] OFF_DATA = 5'h04;

  // region code doubles as the reject cause code
  typedef enum logic [1:0] {
    RGN_REG     = 2'b00,
    RGN_UNDEF   = 2'b01,
    RGN_FLASH   = 2'b10,
    RGN_UNKNOWN = 2'b11
  } region_e;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_LATCH = 2'b01,
    SRC_RFILE = 2'b10
  } rsp_src_e;

endpackage

// File: rtl/iwin_port_decode.sv
module iwin_port_decode #(
  parameter int unsigned OFF_W = 5,
  parameter logic [OFF_W-1:0] ADDR_OFFSET = '0,
  parameter logic [OFF_W-1:0] DATA_OFFSET = OFF_W'(4)
) (
  input  logic [OFF_W-1:0] offset,
  output logic             hit_addr,
  output logic             hit_data
);
  always_comb begin
    hit_addr = (offset == ADDR_OFFSET);
    hit_data = (offset == DATA_OFFSET);
  end
endmodule

// File: rtl/iwin_classify.sv
module iwin_classify
  import iwin_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] REG_END   = ADDR_W'(32'h0001_FFFF),
  parameter logic [ADDR_W-1:0] UNDEF_END = ADDR_W'(32'h0007_FFFF),
  parameter logic [ADDR_W-1:0] FLASH_END = ADDR_W'(32'h000F_FFFF)
) (
  input  logic [ADDR_W-1:0] target,
  output region_e           region
);
  always_comb begin
    if (target < REG_END)        region = RGN_REG;
    else if (target < UNDEF_END) region = RGN_UNDEF;
    else if (target < FLASH_END) region = RGN_FLASH;
    else                         region = RGN_UNKNOWN;
  end
endmodule

// File: rtl/iwin_regfile.sv
module iwin_regfile #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mem[idx];
  end
endmodule

// File: rtl/indirect_window.sv
module indirect_window
  import iwin_pkg::*;
#(
  parameter int unsigned RF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic [1:0]  reject_cause
);
  localparam int unsigned IDX_W = $clog2(RF_DEPTH);

  logic              accept;
  logic              hit_addr, hit_data;
  logic [DATA_W-1:0] addr_latch;
  region_e           region;
  logic              fwd, refuse;
  logic [DATA_W-1:0] rf_q;
  rsp_src_e          rsp_src;
  logic [DATA_W-1:0] latch_snap;

  assign accept = host_valid && host_ready;

  iwin_port_decode #(
    .OFF_W(OFF_W), .ADDR_OFFSET(OFF_ADDR), .DATA_OFFSET(OFF_DATA)
  ) u_dec (
    .offset(host_addr), .hit_addr(hit_addr), .hit_data(hit_data)
  );

  iwin_classify #(.ADDR_W(DATA_W)) u_cls (
    .target(addr_latch), .region(region)
  );

  assign fwd    = accept && hit_data && (region == RGN_REG);
  assign refuse = accept && hit_data && (region != RGN_REG);

  iwin_regfile #(.DEPTH(RF_DEPTH), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(fwd && host_write),
    .rd_en(fwd && !host_write),
    .idx(addr_latch[IDX_W+1:2]),
    .wdata(host_wdata),
    .rdata(rf_q)
  );

  // host side handshake: ready is a registered copy of "out of reset"
  always_ff @(posedge clk) begin
    if (rst) host_ready <= 1'b0;
    else     host_ready <= 1'b1;
  end

  // address latch and sticky reject cause
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_latch   <= '0;
      reject_cause <= RGN_REG;
    end else if (accept && hit_addr && host_write) begin
      addr_latch   <= host_wdata;
      reject_cause <= RGN_REG;
    end else if (refuse) begin
      reject_cause <= region;
    end
  end

  // response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_src    <= SRC_ZERO;
      latch_snap <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        latch_snap <= addr_latch;
        if (host_write)    rsp_src <= SRC_ZERO;
        else if (hit_addr) rsp_src <= SRC_LATCH;
        else if (fwd)      rsp_src <= SRC_RFILE;
        else               rsp_src <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    unique case (rsp_src)
      SRC_LATCH: rsp_rdata = latch_snap;
      SRC_RFILE: rsp_rdata = rf_q;
      default:   rsp_rdata = '0;
    endcase
  end

  // R9: one response per accepted request, in the next cycle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);
  // R9: write responses carry zero data
  a_r9_wr_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && host_write) |=> (rsp_rdata == '0));
  // R8: writing the address latch clears the reject cause
  a_r8_clear_on_addr: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_addr && host_write) |=> (reject_cause == 2'b00));
  // R2: latch takes the full written value
  a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_addr && host_write) |=> (addr_latch == $past(host_wdata)));
  // R3: unused offsets read as zero
  a_r3_other_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_addr && !hit_data) |=> (rsp_rdata == '0));
  // R5/R6/R7: refused data reads return zero and set a nonzero cause
  a_r5_refuse_flag: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (rsp_rdata == '0) && (reject_cause != 2'b00));
  // R4: forwarded accesses leave the cause untouched
  a_r4_fwd_keeps_cause: assert property (@(posedge clk) disable iff (rst)
    fwd |=> $stable(reject_cause));

endmodule

// File: tb/indirect_window_tb_top.sv
module indirect_window_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  reject_cause;

  always #4 clk = ~clk;  // 125 MHz

  indirect_window dut_i (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reject_cause(reject_cause)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_latch;
  logic [31:0] m_mem [64];
  logic [1:0]  m_cause;

  function automatic logic [1:0] region_of(input logic [31:0] a);
    if (a < 32'h0001_FFFF)      return 2'b00;
    else if (a < 32'h0007_FFFF) return 2'b01;
    else if (a < 32'h000F_FFFF) return 2'b10;
    else                        return 2'b11;
  endfunction

  function automatic string tag_of(input logic [1:0] r);
    case (r)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; returns with time at a negedge after checking the response
  task automatic op(input bit wr, input logic [4:0] off, input logic [31:0] d);
    logic [31:0] exp;
    logic [1:0]  r;
    string       tag;
    exp = '0;
    tag = "R3";
    host_valid = 1'b1; host_write = wr; host_addr = off; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    if (off == 5'h00) begin
      tag = "R2";
      if (wr) begin m_latch = d; m_cause = 2'b00; tag = "R8"; end
      else exp = m_latch;
    end else if (off == 5'h04) begin
      r = region_of(m_latch);
      tag = tag_of(r);
      if (r == 2'b00) begin
        if (wr) m_mem[m_latch[7:2]] = d;
        else    exp = m_mem[m_latch[7:2]];
      end else begin
        m_cause = r;
      end
    end
    chk({tag, "/R9 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " rdata"}, rsp_rdata, exp);
    chk({tag, "/R8 cause"}, {30'b0, reject_cause}, {30'b0, m_cause});
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    chk("R9 no response when idle", {31'b0, rsp_valid}, 32'd0);
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 9)
      0, 1, 2: return {22'b0, 8'($urandom), 2'b00};
      3: return 32'h0001_FFFC - ({24'b0, 8'($urandom)} << 2);
      4: return 32'h0001_FFFF + ($urandom % 32'h5_FFFF);
      5: return 32'h0007_FFFF + ($urandom % 32'h7_FFFF);
      6: return 32'h000F_FFFF + ($urandom % 32'h100);
      7: return $urandom | 32'h0010_0000;
      default: return {27'b0, 5'($urandom)} << 2;
    endcase
  endfunction

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240601));
    m_latch = '0; m_cause = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, host_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 cause", {30'b0, reject_cause}, 32'd0);
    op(1'b0, 5'h00, '0);           // R1 latch zero
    op(1'b0, 5'h04, '0);           // R1 register 0 is zero
    idle();

    // R2 full-width latch, R10 back-to-back use
    op(1'b1, 5'h00, 32'hDEAD_BEEF);
    op(1'b0, 5'h00, '0);
    op(1'b1, 5'h00, 32'h0000_0010);
    op(1'b1, 5'h04, 32'hA5A5_0001);   // R10 immediate data write
    op(1'b0, 5'h04, '0);
    // R4 aliasing on bits [7:2]
    op(1'b1, 5'h00, 32'h0000_0110);
    op(1'b0, 5'h04, '0);

    // boundaries R4..R7
    op(1'b1, 5'h00, 32'h0001_FFFE); op(1'b1, 5'h04, 32'h1111_2222); op(1'b0, 5'h04, '0);
    op(1'b1, 5'h00, 32'h0001_FFFF); op(1'b1, 5'h04, 32'h3333_4444); op(1'b0, 5'h04, '0);
    op(1'b1, 5'h00, 32'h0007_FFFE); op(1'b0, 5'h04, '0);
    op(1'b1, 5'h00, 32'h0007_FFFF); op(1'b1, 5'h04, 32'h5555_6666);
    op(1'b1, 5'h00, 32'h000F_FFFE); op(1'b0, 5'h04, '0);
    op(1'b1, 5'h00, 32'h000F_FFFF); op(1'b1, 5'h04, 32'h7777_8888);
    // R8 sticky: later refusal overwrites, address read does not clear
    op(1'b1, 5'h00, 32'hFFFF_FFFF); op(1'b0, 5'h04, '0);
    op(1'b0, 5'h00, '0);
    op(1'b1, 5'h08, 32'h1234_5678);  // R3 ignored write
    op(1'b0, 5'h00, '0);
    // R3 unused offsets and a refused write leave registers intact
    op(1'b1, 5'h00, 32'h0000_00FC); op(1'b0, 5'h04, '0);
    op(1'b1, 5'h1C, 32'hCAFE_F00D); op(1'b0, 5'h1C, '0);
    op(1'b0, 5'h04, '0); op(1'b0, 5'h00, '0);
    op(1'b1, 5'h05, 32'h0BAD_0BAD); op(1'b0, 5'h04, '0);
    idle();

    // randomized mix
    for (int k = 0; k < 600; k++) begin
      case ($urandom % 8)
        0, 1:    op(1'b1, 5'h00, pick_addr());
        2, 3:    op(1'b1, 5'h04, $urandom);
        4, 5:    op(1'b0, 5'h04, '0);
        6:       op(1'b0, 5'h00, '0);
        default: begin
          if ($urandom % 2) op($urandom % 2 == 1, 5'($urandom), $urandom);
          else idle();
        end
      endcase
    end
    // final sweep of register contents through the window
    for (int j = 0; j < 64; j++) begin
      op(1'b1, 5'h00, 32'(j) << 2);
      op(1'b0, 5'h04, '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule